// File: doc/BRIEF.md
# Serial-Operand Shift-and-Add Multiplier

This block multiplies two 8-bit unsigned numbers that reach it one after the other over a single shared input bus. The multiplier operand is taken while the block signals that it is ready, and the multiplicand follows on the next clock. Internally there are three registers: a shifting multiplier, a shifting multiplicand and an accumulator. One ALU serves all of them, and a one-hot controller sequences the work. The accumulator is zeroed by an ALU XOR of the multiplier register with itself. Each loop pass shifts the multiplier right and adds the multiplicand when the bit that falls out is set. The loop stops as soon as no set multiplier bits remain.

The product is truncated to the bus width. An overflow flag reports, exactly, when the true product does not fit. It is raised either by a carry out of an accumulate or by a set bit pushed out of the top of the multiplicand while multiplier bits remain. The block has no idle state. When an operation ends, the controller returns to its operand-capture state, so the ready pulse lasts exactly one cycle and the next operand is taken in that same cycle.

Top module: `shadd_mul`

## Requirements
- R1: `ready` is high for exactly one cycle per operation. The value on `bus_in` at the rising edge that ends that cycle becomes the multiplier. `ready` is low in the following cycle, and `bus_in` at the edge ending that cycle becomes the multiplicand. Later bus values have no effect on the result.
- R2: The accumulator is cleared before the loop starts, so `product` reads 0 in the third cycle after the multiplier capture edge.
- R3: When the true product a*b is at most 255, `product` equals a*b in the cycle `ready` returns high.
- R4: In the cycle `ready` returns high, `ovf` is 1 exactly when a*b exceeds 255. `ovf` never changes while `ready` is low.
- R5: Termination is early. For multiplicand b ≠ 0 and no overflow, let n be one plus the index of the highest set bit of a (n = 0 for a = 0) and p the number of set bits of a. `ready` is then low for 2 + max(n,1) + p + max(n-1,0) cycles.
- R6: After an overflowed operation, the next operation is accepted in the same ready cycle and computes normally. `ovf` is 0 at its end when its product fits.
- R7: `product` and `ovf` keep their end-of-operation values during the ready cycle and the cycle after it.
- R8: While `rst` (synchronous, active high) is asserted, `ready` is 1, `product` is 0 and `ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | W (8) | Shared operand bus: multiplier, then multiplicand |
| ready | output | 1 | High in the one cycle the multiplier is captured |
| product | output | W (8) | Accumulator, the truncated product once ready rises |
| ovf | output | 1 | Set when the last operation's true product overflowed |

## Verification
The bench sweeps every multiplier value against twenty multiplicands, chosen to include zero, powers of two, all-ones and values near the overflow boundary. It compares `product` and `ovf` with the arithmetic product, and compares the busy time with the closed-form latency. Several kinds of defect show up as mismatches:
- Dropping the carry test would report a wrapped product with no overflow.
- Ignoring the bit pushed out of the multiplicand would miss overflows such as 2×128.
- Testing the multiplicand shift before the multiplier is exhausted would flag false overflows such as 1×255.
- A loop that does not stop early would run too long for small multipliers.

An overflow followed directly by a fitting product catches a sticky flag. Driving junk on the bus after the multiplicand slot catches late sampling.

// File: rtl/shadd_mul_pkg.sv
package shadd_mul_pkg;

    typedef enum logic [3:0] {
        OP_SHL  = 4'b0010,
        OP_SHR  = 4'b0011,
        OP_PASS = 4'b0100,
        OP_XOR  = 4'b0110,
        OP_ADD  = 4'b1011
    } alu_op_e;

    localparam int unsigned NSTATE = 8;

    typedef enum logic [NSTATE-1:0] {
        ST_START = 8'b0000_0001,
        ST_GETY  = 8'b0000_0010,
        ST_CLR   = 8'b0000_0100,
        ST_SHX   = 8'b0000_1000,
        ST_ADD   = 8'b0001_0000,
        ST_SHY   = 8'b0010_0000,
        ST_LAST  = 8'b0100_0000,
        ST_OVF   = 8'b1000_0000
    } state_e;

    typedef enum logic [1:0] {
        SRC_BUS = 2'd0,
        SRC_X   = 2'd1,
        SRC_Y   = 2'd2
    } lsrc_e;

    typedef struct packed {
        lsrc_e   lsrc;
        logic    rself;
        alu_op_e op;
        logic    ld_x;
        logic    ld_y;
        logic    ld_r;
        logic    ready;
    } ctl_t;

endpackage

// File: rtl/shadd_mul_alu.sv
module shadd_mul_alu
    import shadd_mul_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         cy,
    output logic         zf
);
    localparam int unsigned SW = W + 1;

    logic [SW-1:0] sum;

    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        res = a;
        cy  = 1'b0;
        unique case (op)
            OP_PASS: res = a;
            OP_SHR:  begin res = a >> 1; cy = a[0];   end
            OP_SHL:  begin res = a << 1; cy = a[W-1]; end
            OP_XOR:  res = a ^ b;
            OP_ADD:  begin res = sum[W-1:0]; cy = sum[W]; end
            default: res = a;
        endcase
        zf = (res == '0);
    end
endmodule

// File: rtl/shadd_mul_ctrl.sv
module shadd_mul_ctrl
    import shadd_mul_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cy,
    input  logic zf,
    output ctl_t ctl,
    output logic ovf
);
    typedef struct packed {
        state_e st;
        logic   ovf;
    } ctrl_s;

    ctrl_s q, n;

    always_comb begin
        n         = q;
        ctl.lsrc  = SRC_BUS;
        ctl.rself = 1'b0;
        ctl.op    = OP_PASS;
        ctl.ld_x  = 1'b0;
        ctl.ld_y  = 1'b0;
        ctl.ld_r  = 1'b0;
        ctl.ready = 1'b0;
        unique case (q.st)
            ST_START, ST_OVF: begin
                ctl.ld_x  = 1'b1;
                ctl.ready = 1'b1;
                n.st      = ST_GETY;
            end
            ST_GETY: begin
                ctl.ld_y = 1'b1;
                n.st     = ST_CLR;
            end
            ST_CLR: begin
                ctl.lsrc  = SRC_X;
                ctl.rself = 1'b1;
                ctl.op    = OP_XOR;
                ctl.ld_r  = 1'b1;
                n.st      = ST_SHX;
            end
            ST_SHX: begin
                ctl.lsrc = SRC_X;
                ctl.op   = OP_SHR;
                ctl.ld_x = 1'b1;
                unique case ({cy, zf})
                    2'b00:   n.st = ST_SHY;
                    2'b01:   n.st = ST_START;
                    2'b10:   n.st = ST_ADD;
                    default: n.st = ST_LAST;
                endcase
            end
            ST_ADD: begin
                ctl.lsrc = SRC_Y;
                ctl.op   = OP_ADD;
                ctl.ld_r = 1'b1;
                if (cy)      n.st = ST_OVF;
                else if (zf) n.st = ST_START;
                else         n.st = ST_SHY;
            end
            ST_SHY: begin
                ctl.lsrc = SRC_Y;
                ctl.op   = OP_SHL;
                ctl.ld_y = 1'b1;
                n.st     = cy ? ST_OVF : ST_SHX;
            end
            ST_LAST: begin
                ctl.lsrc = SRC_Y;
                ctl.op   = OP_ADD;
                ctl.ld_r = 1'b1;
                n.st     = cy ? ST_OVF : ST_START;
            end
            default: n.st = ST_START;
        endcase
        if (n.st == ST_START)    n.ovf = 1'b0;
        else if (n.st == ST_OVF) n.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st  <= ST_START;
            q.ovf <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign ovf = q.ovf;
endmodule

// File: rtl/shadd_mul_dp.sv
module shadd_mul_dp
    import shadd_mul_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_in,
    input  ctl_t         ctl,
    output logic [W-1:0] acc,
    output logic         cy,
    output logic         zf
);
    typedef struct packed {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] r;
    } regs_s;

    regs_s        q, n;
    logic [W-1:0] left_op, right_op, alu_res;

    always_comb begin
        unique case (ctl.lsrc)
            SRC_X:   left_op = q.x;
            SRC_Y:   left_op = q.y;
            default: left_op = bus_in;
        endcase
        right_op = ctl.rself ? left_op : q.r;
    end

    shadd_mul_alu #(.W(W)) i_alu (
        .op  (ctl.op),
        .a   (left_op),
        .b   (right_op),
        .res (alu_res),
        .cy  (cy),
        .zf  (zf)
    );

    always_comb begin
        n = q;
        if (ctl.ld_x) n.x = alu_res;
        if (ctl.ld_y) n.y = alu_res;
        if (ctl.ld_r) n.r = alu_res;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    assign acc = q.r;
endmodule

// File: rtl/shadd_mul.sv
module shadd_mul
    import shadd_mul_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_in,
    output logic         ready,
    output logic [W-1:0] product,
    output logic         ovf
);
    ctl_t ctl;
    logic alu_cy, alu_zf;

    shadd_mul_ctrl i_ctrl (
        .clk (clk),
        .rst (rst),
        .cy  (alu_cy),
        .zf  (alu_zf),
        .ctl (ctl),
        .ovf (ovf)
    );

    shadd_mul_dp #(.W(W)) i_dp (
        .clk    (clk),
        .rst    (rst),
        .bus_in (bus_in),
        .ctl    (ctl),
        .acc    (product),
        .cy     (alu_cy),
        .zf     (alu_zf)
    );

    assign ready = ctl.ready;
endmodule

// File: rtl/shadd_mul_chk.sv
module shadd_mul_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         ready,
    input logic [W-1:0] product,
    input logic         ovf
);
    assert_ready_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    assert_gety_low_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |=> !ready);

    assert_acc_cleared_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(ready, 3) && !$past(ready, 2)) |-> (product == '0));

    assert_ovf_steady_R4: assert property (@(posedge clk) disable iff (rst)
        !ready |-> $stable(ovf));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ready |=> ($stable(product) && $stable(ovf)));

    assert_reset_state_R8: assert property (@(posedge clk)
        $past(rst) |-> (ready && product == '0 && !ovf));
endmodule

bind shadd_mul shadd_mul_chk #(.W(W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .ready   (ready),
    .product (product),
    .ovf     (ovf)
);

// File: tb/test_shadd_mul.sv
`timescale 1ns/1ps
module test_shadd_mul;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_in;
    logic       ready;
    logic [7:0] product;
    logic       ovf;

    int total = 0;
    int fails = 0;
    int prev_p = 0;
    int prev_o = 0;
    int got_p, got_o, got_low;

    always #2.5 clk = ~clk;

    shadd_mul i_shadd_mul (
        .clk     (clk),
        .rst     (rst),
        .bus_in  (bus_in),
        .ready   (ready),
        .product (product),
        .ovf     (ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_low(input int a);
        int n = 0;
        int p = 0;
        for (int i = 0; i < 8; i++) begin
            if (a[i]) begin
                n = i + 1;
                p++;
            end
        end
        return 2 + ((n > 0) ? n : 1) + p + ((n > 0) ? n - 1 : 0);
    endfunction

    // Called at a negedge with ready high.
    task automatic run_op(input int a, input int b);
        int low;
        bus_in = a[7:0];
        @(negedge clk);
        low = 1;
        chk(ready == 1'b0, "R1 ready low after capture", int'(ready), 0);
        chk(int'(product) == prev_p && int'(ovf) == prev_o, "R7 result held",
            int'(product), prev_p);
        bus_in = b[7:0];
        @(negedge clk);
        low = 2;
        bus_in = ~b[7:0] ^ 8'h5A;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (ready) break;
            low++;
            if (low == 3) chk(product == 8'd0, "R2 accumulator cleared", int'(product), 0);
        end
        got_p   = int'(product);
        got_o   = int'(ovf);
        got_low = low;
        begin
            int full = a * b;
            int eo   = (full > 255) ? 1 : 0;
            chk(got_o == eo, $sformatf("R4 ovf a=%0d b=%0d", a, b), got_o, eo);
            if (eo == 0) begin
                chk(got_p == full, $sformatf("R3 product a=%0d b=%0d", a, b), got_p, full);
                if (b != 0)
                    chk(got_low == exp_low(a), $sformatf("R5 latency a=%0d", a),
                        got_low, exp_low(a));
            end
        end
        prev_p = got_p;
        prev_o = got_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int bvals[20] = '{0, 1, 2, 3, 4, 5, 7, 8, 15, 16, 17, 31, 32, 51, 63, 64, 85,
                          127, 128, 255};
        rst    = 1'b1;
        bus_in = 8'h00;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(ready == 1'b1, "R8 reset ready", int'(ready), 1);
        chk(product == 8'd0, "R8 reset product", int'(product), 0);
        chk(ovf == 1'b0, "R8 reset ovf", int'(ovf), 0);
        rst = 1'b0;

        run_op(200, 2);
        chk(got_o == 1, "R6 first op overflows", got_o, 1);
        run_op(3, 4);
        chk(got_o == 0, "R6 ovf cleared after overflow", got_o, 0);
        chk(got_p == 12, "R6 product after overflow", got_p, 12);
        run_op(2, 128);
        chk(got_o == 1, "R4 shifted-out multiplicand bit", got_o, 1);
        run_op(1, 255);
        chk(got_o == 0 && got_p == 255, "R4 no false overflow 1x255", got_p, 255);

        foreach (bvals[j]) begin
            for (int a = 0; a < 256; a++) run_op(a, bvals[j]);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule